// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This unit multiplies two 16-bit operands in one cycle and folds the product into one of two 40-bit accumulators. On each clock edge the selected accumulator can be loaded with the product, have the product added to it, have it subtracted from it, be left alone, or be cleared. Each operation touches only the accumulator that is selected. The operands may be treated as two's-complement or as unsigned numbers. The eight bits above the 32-bit product give headroom, so long sums can run past the 32-bit range without wrapping.

The read side works without a clock. It shows whichever accumulator the select input names, in two forms. The first is the full 40-bit value. The second is a 16-bit result: the upper half of the low 32 bits, optionally rounded to nearest, and clamped to the most positive or most negative 16-bit code when the value does not fit. An overflow flag reports when the 40-bit value has left the 32-bit signed range. Operand routing and instruction decode are handled by the surrounding datapath.

Top module: `dacc_mac`

## Requirements
- R1: While `rst_n` is low, and after it rises, both accumulators read zero. `res_o` is 0x0000 and `ovf_o` is 0.
- R2: `op_i` = 2'b01 loads the selected accumulator with the extended product of `a_i` and `b_i`.
- R3: `op_i` = 2'b10 adds the extended product to the selected accumulator, modulo 2^40.
- R4: `op_i` = 2'b11 subtracts the extended product from the selected accumulator, modulo 2^40.
- R5: `op_i` = 2'b00 leaves the selected accumulator unchanged.
- R6: With `sgn_i` = 1 both operands are two's-complement and the 32-bit product is sign-extended to 40 bits. With `sgn_i` = 0 both operands are unsigned and the product is zero-extended.
- R7: An edge changes only the accumulator named by `acc_sel_i` (0 or 1). The other one keeps its value.
- R8: `clr_i` = 1 zeros the selected accumulator whatever `op_i` is, and leaves the other accumulator as it was.
- R9: `acc_o`, `res_o` and `ovf_o` follow `acc_sel_i` and `rnd_i` with no clock. An update is visible from the edge on which it is written.
- R10: `ovf_o` is 1 exactly when bits 39 down to 31 of the shown accumulator are not all equal.
- R11: When `ovf_o` is 1, `res_o` is 0x7FFF if bit 39 is 0, and 0x8000 if bit 39 is 1.
- R12: When `ovf_o` is 0 and `rnd_i` is 0, `res_o` equals bits 31 down to 16 of the shown accumulator.
- R13: When `ovf_o` is 0 and `rnd_i` is 1, 0x8000 is added to the accumulator and `res_o` takes bits 31 down to 16 of the sum. If that sum has left the 32-bit signed range, `res_o` is 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accumulators update on the rising edge |
| rst_n | input | 1 | Active-low reset, zeros both accumulators |
| op_i | input | 2 | 00 hold, 01 multiply-load, 10 multiply-add, 11 multiply-subtract |
| acc_sel_i | input | 1 | Accumulator written on the edge and shown on the outputs |
| sgn_i | input | 1 | 1: signed operands; 0: unsigned operands |
| clr_i | input | 1 | Zero the selected accumulator (takes priority over op_i) |
| rnd_i | input | 1 | Round to nearest in the 16-bit result |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| acc_o | output | 40 | Selected accumulator |
| res_o | output | 16 | Rounded or saturated upper result |
| ovf_o | output | 1 | Selected accumulator exceeds the 32-bit signed range |

## Verification
All state sits in the two accumulators, so a wrong update shows on `acc_o` on the very edge it is written, provided the same accumulator is still selected. If a write lands in the wrong accumulator, the damage stays hidden until that accumulator is selected again. For that reason the stimulus switches between the two accumulators and rereads the idle one after long runs on the other. Faults in the rounding and clamping logic need no clock to appear: they show on `res_o` as soon as the accumulator value crosses the 0x8000 rounding boundary or the 32-bit signed limit.

// File: rtl/dacc_mac_pkg.sv
package dacc_mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_LOAD = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } mac_op_e;

    // true when the bits above the signed window of width w disagree
    function automatic logic window_exceeded(input logic [63:0] v, input int aw, input int w);
        logic all0;
        logic all1;
        all0 = 1'b1;
        all1 = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i >= w - 1 && i < aw) begin
                all0 = all0 & ~v[i];
                all1 = all1 & v[i];
            end
        end
        return ~(all0 | all1);
    endfunction

endpackage

// File: rtl/dacc_mac_mult.sv
module dacc_mac_mult
    import dacc_mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sgn_i,
    output logic [AW-1:0] prod_o
);
    localparam int PW = 2 * DW + 2;

    logic signed [DW:0]   a_x;
    logic signed [DW:0]   b_x;
    logic signed [PW-1:0] p;

    // one extra bit per operand: sign copy in signed mode, zero otherwise
    assign a_x = {sgn_i & a_i[DW-1], a_i};
    assign b_x = {sgn_i & b_i[DW-1], b_i};
    assign p   = PW'(a_x) * PW'(b_x);

    generate
        if (AW > PW) begin : g_ext
            assign prod_o = {{(AW-PW){p[PW-1]}}, p};
        end else begin : g_trunc
            assign prod_o = p[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/dacc_mac_bank.sv
module dacc_mac_bank
    import dacc_mac_pkg::*;
#(
    parameter int AW   = 40,
    parameter int NACC = 2,
    parameter int SELW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel_i,
    input  logic            clr_i,
    input  mac_op_e         op_i,
    input  logic [AW-1:0]   prod_i,
    output logic [AW-1:0]   rd_o
);
    logic [AW-1:0] acc_q [NACC];
    logic [AW-1:0] nxt;

    assign rd_o = acc_q[sel_i];

    always_comb begin
        if (clr_i) begin
            nxt = '0;
        end else begin
            unique case (op_i)
                OP_HOLD: nxt = rd_o;
                OP_LOAD: nxt = prod_i;
                OP_ADD:  nxt = rd_o + prod_i;
                OP_SUB:  nxt = rd_o - prod_i;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NACC; g++) begin : g_acc
            logic [AW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (sel_i == SELW'(g)) begin
                    q <= nxt;
                end
            end
            assign acc_q[g] = q;
        end
    endgenerate

endmodule

// File: rtl/dacc_mac_readout.sv
module dacc_mac_readout
    import dacc_mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc_i,
    input  logic          rnd_i,
    output logic [DW-1:0] res_o,
    output logic          ovf_o
);
    localparam int          W32    = 2 * DW;
    localparam logic [AW-1:0] HALF = AW'(1) << (DW - 1);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

    logic [AW-1:0] rounded;
    logic [AW-1:0] picked;
    logic          rnd_ovf;
    logic          sat;

    assign rounded = acc_i + HALF;
    assign ovf_o   = window_exceeded(64'(acc_i), AW, W32);
    assign rnd_ovf = window_exceeded(64'(rounded), AW, W32);
    assign picked  = rnd_i ? rounded : acc_i;
    assign sat     = ovf_o | (rnd_i & rnd_ovf);

    always_comb begin
        if (sat) begin
            res_o = acc_i[AW-1] ? NEG_MAX : POS_MAX;
        end else begin
            res_o = picked[W32-1:DW];
        end
    end

endmodule

// File: rtl/dacc_mac.sv
module dacc_mac
    import dacc_mac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 8,
    parameter int NACC  = 2,
    localparam int AW   = 2 * DW + GUARD,
    localparam int SELW = (NACC > 1) ? $clog2(NACC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      op_i,
    input  logic [SELW-1:0] acc_sel_i,
    input  logic            sgn_i,
    input  logic            clr_i,
    input  logic            rnd_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [AW-1:0]   acc_o,
    output logic [DW-1:0]   res_o,
    output logic            ovf_o
);
    logic [AW-1:0] prod;
    mac_op_e       op;

    assign op = mac_op_e'(op_i);

    dacc_mac_mult #(.DW(DW), .AW(AW)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .sgn_i  (sgn_i),
        .prod_o (prod)
    );

    dacc_mac_bank #(.AW(AW), .NACC(NACC), .SELW(SELW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (acc_sel_i),
        .clr_i  (clr_i),
        .op_i   (op),
        .prod_i (prod),
        .rd_o   (acc_o)
    );

    dacc_mac_readout #(.DW(DW), .AW(AW)) u_read (
        .acc_i (acc_o),
        .rnd_i (rnd_i),
        .res_o (res_o),
        .ovf_o (ovf_o)
    );

endmodule

// File: rtl/dacc_mac_chk.sv
module dacc_mac_chk #(
    parameter int DW   = 16,
    parameter int AW   = 40,
    parameter int SELW = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      op_i,
    input logic [SELW-1:0] acc_sel_i,
    input logic            sgn_i,
    input logic            clr_i,
    input logic            rnd_i,
    input logic [DW-1:0]   a_i,
    input logic [DW-1:0]   b_i,
    input logic [AW-1:0]   acc_o,
    input logic [DW-1:0]   res_o,
    input logic            ovf_o
);
    logic [AW-1:0] ref_prod_q;
    logic signed [DW:0] ax;
    logic signed [DW:0] bx;

    assign ax = {sgn_i & a_i[DW-1], a_i};
    assign bx = {sgn_i & b_i[DW-1], b_i};

    always_ff @(posedge clk) begin
        ref_prod_q <= AW'(ax * bx);
    end

    AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && op_i == 2'b01) |=> ((acc_sel_i != $past(acc_sel_i)) || (acc_o == ref_prod_q))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && op_i == 2'b00) |=> ((acc_sel_i != $past(acc_sel_i)) || (acc_o == $past(acc_o)))); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((acc_sel_i != $past(acc_sel_i)) || (acc_o == '0))); // R8

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (res_o == (acc_o[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}}))); // R11

    AST_PLAIN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && !rnd_i) |-> (res_o == acc_o[2*DW-1:DW])); // R12

endmodule

bind dacc_mac dacc_mac_chk #(.DW(DW), .AW(AW), .SELW(SELW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .acc_sel_i (acc_sel_i),
    .sgn_i     (sgn_i),
    .clr_i     (clr_i),
    .rnd_i     (rnd_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .acc_o     (acc_o),
    .res_o     (res_o),
    .ovf_o     (ovf_o)
);

// File: tb/tb_dacc_mac.sv
`timescale 1ns/100ps
module tb_dacc_mac;

    typedef struct packed {
        logic [1:0]  op;
        logic        sel;
        logic        sgn;
        logic        clr;
        logic        rnd;
        logic [15:0] a;
        logic [15:0] b;
        logic [39:0] acc;
        logic [15:0] res;
        logic        ovf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    // op: 0 hold, 1 load, 2 add, 3 subtract
    localparam vec_t VEC [NV] = '{
        '{2'd1,1'b0,1'b1,1'b0,1'b0,16'h0003,16'h0004,40'h00_0000_000C,16'h0000,1'b0,8'd2},  // R2
        '{2'd2,1'b0,1'b1,1'b0,1'b0,16'hFFFE,16'h0005,40'h00_0000_0002,16'h0000,1'b0,8'd3},  // R3, R6 signed
        '{2'd1,1'b1,1'b1,1'b0,1'b0,16'h4000,16'h4000,40'h00_1000_0000,16'h1000,1'b0,8'd2},  // R2
        '{2'd3,1'b1,1'b1,1'b0,1'b1,16'h0100,16'h0010,40'h00_0FFF_F000,16'h1000,1'b0,8'd4},  // R4, R13
        '{2'd0,1'b0,1'b1,1'b0,1'b0,16'h1234,16'h5678,40'h00_0000_0002,16'h0000,1'b0,8'd7},  // R5, R7
        '{2'd1,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFF,40'h00_FFFE_0001,16'h7FFF,1'b1,8'd6},  // R6 unsigned, R11
        '{2'd1,1'b0,1'b1,1'b0,1'b0,16'h8000,16'h8000,40'h00_4000_0000,16'h4000,1'b0,8'd2},  // R2
        '{2'd2,1'b0,1'b1,1'b0,1'b0,16'h8000,16'h8000,40'h00_8000_0000,16'h7FFF,1'b1,8'd10}, // R10
        '{2'd3,1'b1,1'b1,1'b0,1'b0,16'h7FFF,16'h7FFF,40'hFF_D000_EFFF,16'hD000,1'b0,8'd12}, // R4, R12
        '{2'd2,1'b1,1'b1,1'b0,1'b1,16'h8000,16'h7FFF,40'hFF_9001_6FFF,16'h9001,1'b0,8'd13}, // R3, R13
        '{2'd2,1'b1,1'b1,1'b0,1'b0,16'h8000,16'h7FFF,40'hFF_5001_EFFF,16'h8000,1'b1,8'd11}, // R11
        '{2'd2,1'b1,1'b1,1'b1,1'b0,16'h0001,16'h0001,40'h00_0000_0000,16'h0000,1'b0,8'd8},  // R8
        '{2'd0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,40'h00_8000_0000,16'h7FFF,1'b1,8'd8},  // R8 other kept
        '{2'd1,1'b0,1'b0,1'b0,1'b1,16'h8000,16'hFFFF,40'h00_7FFF_8000,16'h7FFF,1'b0,8'd13}, // R13 carry clamp
        '{2'd1,1'b0,1'b0,1'b0,1'b1,16'h8000,16'h0001,40'h00_0000_8000,16'h0001,1'b0,8'd13}, // R13 half up
        '{2'd1,1'b0,1'b0,1'b0,1'b1,16'h7FFF,16'h0001,40'h00_0000_7FFF,16'h0000,1'b0,8'd13}, // R13 below half
        '{2'd0,1'b1,1'b1,1'b0,1'b0,16'h0000,16'h0000,40'h00_0000_0000,16'h0000,1'b0,8'd7},  // R7
        '{2'd3,1'b0,1'b1,1'b0,1'b0,16'h0001,16'h0001,40'h00_0000_7FFE,16'h0000,1'b0,8'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [0:0]  acc_sel_i = 1'b0;
    logic        sgn_i = 1'b1;
    logic        clr_i = 1'b0;
    logic        rnd_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [39:0] acc_o;
    logic [15:0] res_o;
    logic        ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dacc_mac dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .acc_sel_i (acc_sel_i),
        .sgn_i     (sgn_i),
        .clr_i     (clr_i),
        .rnd_i     (rnd_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .acc_o     (acc_o),
        .res_o     (res_o),
        .ovf_o     (ovf_o)
    );

    task automatic check(input int req, input string what, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [39:0] e_acc, input logic [15:0] e_res, input logic e_ovf);
        check(req, "acc", acc_o, e_acc);
        check(req, "res", 40'(res_o), 40'(e_res));
        check(req, "ovf", 40'(ovf_o), 40'(e_ovf));
    endtask

    task automatic drive(input logic [1:0] op, input logic sel, input logic sgn, input logic clr,
                         input logic rnd, input logic [15:0] a, input logic [15:0] b);
        op_i = op; acc_sel_i = sel; sgn_i = sgn; clr_i = clr; rnd_i = rnd; a_i = a; b_i = b;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, both accumulators
        repeat (3) @(negedge clk);
        check_all(1, 40'h0, 16'h0000, 1'b0);
        acc_sel_i = 1'b1;
        #1;
        check_all(1, 40'h0, 16'h0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1, 40'h0, 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].sel, VEC[i].sgn, VEC[i].clr, VEC[i].rnd, VEC[i].a, VEC[i].b);
            @(negedge clk);
            check_all(int'(VEC[i].req), VEC[i].acc, VEC[i].res, VEC[i].ovf);
        end

        // R9: outputs follow select and rounding with no clock edge
        drive(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0002, 16'h0003);
        @(negedge clk);
        check(2, "acc1 load", acc_o, 40'h6);
        drive(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000);
        #1;
        check(9, "switch to acc0", acc_o, 40'h00_0000_7FFE);
        acc_sel_i = 1'b1;
        #1;
        check(9, "switch to acc1", acc_o, 40'h6);
        // R13 versus R12 on the same value: rounding input alone
        drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0080);
        @(negedge clk);
        check(12, "no round", 40'(res_o), 40'h0000);
        rnd_i = 1'b1;
        #1;
        check(13, "round up", 40'(res_o), 40'h0001);

        // R1: reset in mid-run zeros both accumulators
        rst_n = 1'b0;
        #1;
        check_all(1, 40'h0, 16'h0000, 1'b0);
        acc_sel_i = 1'b0;
        #1;
        check_all(1, 40'h0, 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule